// File: doc/BRIEF.md
# Binary-Decade Saturating Timer Bank

This block holds a bank of byte-wide countdown timers for control logic that must measure many intervals at once. The timers are split into rate groups. The first group counts at the base tick rate, and each group after it counts at half the rate of the group before. One shared modulo counter steps on every base tick, and its low bits decide which groups take a step on that tick. A long interval therefore fits into one byte, at a coarser resolution.

A client starts a timer by loading a count through the single load port, addressed by a flat timer index. The timer then counts down, stops at zero and raises its expired flag. The flag stays up until a new count is loaded. Flat index `g*TIMERS_PER_GROUP + s` names slot `s` of group `g`, so with the default parameters indices 0-3 count every tick, 4-7 count every second tick and 8-11 count every fourth tick.

Top module: `timer_bank`

## Requirements
- R1: Each timer holds a TMR_W-bit count, 8 bits by default. A load of a non-zero value makes that timer read as not expired from the cycle after the load.
- R2: When its group takes a step, a timer goes down by exactly one if it is non-zero. At zero it stays at zero and never wraps to the maximum value.
- R3: Bit i of `expired_o` is 1 exactly when timer i holds zero.
- R4: The shared modulo counter advances by one on each cycle with `tick_i` high and holds otherwise. With `tick_i` low, no timer changes.
- R5: Group 0 steps on every base tick.
- R6: Group 1 steps only on ticks after which bit 0 of the advanced modulo counter is 1. From reset these are the 1st, 3rd, 5th... ticks.
- R7: Group g steps on ticks after which the low g bits of the advanced modulo counter are all ones, which is once every 2^g ticks. From reset, group 2 steps on the 3rd, 7th, 11th... ticks.
- R8: If a load and a group step reach the same timer in the same cycle, the timer takes the loaded value and the step is lost.
- R9: Synchronous active-low reset clears every timer and the modulo counter, so all expired flags read 1 after reset.
- R10: A load whose index is not below the number of timers changes no timer.
- R11: A load of zero makes the addressed timer read as expired from the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_i | input | 1 | Base time tick, one cycle wide per tick |
| load_i | input | 1 | Load strobe |
| load_idx_i | input | IDX_W | Flat index of the timer to load |
| load_val_i | input | TMR_W | Count to load |
| expired_o | output | N_TIMERS | Per-timer flag, 1 when the count is zero |

## Verification
Assertions check these rules on every cycle: the counter step and hold, the nesting of group step enables, one-down-or-hold at zero inside every timer, the load-over-step priority, the reset clearing, and that an out-of-range load disturbs nothing. The directed scenarios must show the rest, because it only appears at the flags over whole runs: the exact tick on which a timer in each group expires for a given count and counter phase, the full 255-tick span, a zero load, and the behaviour after a reset in the middle of a run.

// File: rtl/tbt_pkg.sv
// Package: shared helpers for the timer bank.
// Assumes counter values fit in 32 bits.
package tbt_pkg;

    // True when the low 'lvl' bits of 'cnt' are all ones (lvl 0 is always true).
    function automatic logic rate_hit(input int unsigned cnt, input int unsigned lvl);
        int unsigned msk;
        msk = (32'd1 << lvl) - 32'd1;
        return (cnt & msk) == msk;
    endfunction

endpackage

// File: rtl/tbt_rate_sched.sv
// Rate scheduler: owns the shared modulo counter. On every base tick it
// steps the counter and raises the step enable of each group whose rate
// matches the advanced counter value. Assumes CNT_W >= N_GROUPS-1.
module tbt_rate_sched #(
    parameter int N_GROUPS = 3,
    parameter int CNT_W    = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    output logic [N_GROUPS-1:0] grp_en_o
);
    import tbt_pkg::*;

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] cnt_nx;

    // Advanced counter value that the enables are decoded from.
    always_comb cnt_nx = cnt_q + 1'b1;

    // Modulo counter: steps once per base tick.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_i) cnt_q <= cnt_nx;
    end

    // One enable per group, each at half the rate of the one before.
    for (genvar g = 0; g < N_GROUPS; g++) begin : g_en
        assign grp_en_o[g] = tick_i & rate_hit(32'(cnt_nx), g);
    end

    AST_CNT_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1)); // R4
    AST_CNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |=> $stable(cnt_q)); // R4
    AST_NO_TICK_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !tick_i |-> grp_en_o == '0); // R4
    AST_BASE_EVERY_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        tick_i |-> grp_en_o[0]); // R5

    for (genvar g = 1; g < N_GROUPS; g++) begin : g_nest
        AST_RATE_HALVES: assert property (@(posedge clk) disable iff (!rst_n)
            grp_en_o[g] |-> grp_en_o[g-1]); // R7
    end

endmodule

// File: rtl/tbt_timer_cell.sv
// Timer cell: one saturating countdown register. A load takes priority
// over a step. Assumes ld_i and dec_i are single-cycle qualified strobes.
module tbt_timer_cell #(
    parameter int TMR_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_i,
    input  logic [TMR_W-1:0] ld_val_i,
    input  logic             dec_i,
    output logic             zero_o
);
    logic [TMR_W-1:0] cnt_q;

    // Count register: load first, otherwise step down unless already zero.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (ld_i)                 cnt_q <= ld_val_i;
        else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end

    // Expired flag is the zero test of the count.
    always_comb zero_o = (cnt_q == '0);

    AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        ld_i |=> cnt_q == $past(ld_val_i)); // R8
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && dec_i && cnt_q != '0) |=> cnt_q == TMR_W'($past(cnt_q) - 1'b1)); // R2
    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && zero_o) |=> zero_o); // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_i && !dec_i) |=> $stable(cnt_q)); // R4

endmodule

// File: rtl/tbt_timer_group.sv
// Timer group: SIZE cells sharing one step enable. Cell s answers to flat
// index BASE+s. Assumes BASE+SIZE fits in IDX_W bits.
module tbt_timer_group #(
    parameter int TMR_W = 8,
    parameter int SIZE  = 4,
    parameter int IDX_W = 4,
    parameter int BASE  = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_i,
    input  logic             ld_i,
    input  logic [IDX_W-1:0] ld_idx_i,
    input  logic [TMR_W-1:0] ld_val_i,
    output logic [SIZE-1:0]  zero_o
);
    for (genvar s = 0; s < SIZE; s++) begin : g_cell
        logic hit;
        // Address decode for this slot.
        always_comb hit = ld_i && (ld_idx_i == IDX_W'(BASE + s));

        tbt_timer_cell #(.TMR_W(TMR_W)) u_cell (
            .clk      (clk),
            .rst_n    (rst_n),
            .ld_i     (hit),
            .ld_val_i (ld_val_i),
            .dec_i    (step_i),
            .zero_o   (zero_o[s])
        );
    end

endmodule

// File: rtl/timer_bank.sv
// Timer bank top: N_GROUPS groups of TIMERS_PER_GROUP byte timers. Group g
// steps once every 2^g base ticks. Assumes tick_i is a one-cycle pulse.
module timer_bank #(
    parameter int TMR_W            = 8,
    parameter int N_GROUPS         = 3,
    parameter int TIMERS_PER_GROUP = 4,
    localparam int N_TIMERS        = N_GROUPS * TIMERS_PER_GROUP,
    localparam int IDX_W           = (N_TIMERS > 1) ? $clog2(N_TIMERS) : 1,
    localparam int CNT_W           = (N_GROUPS > 1) ? N_GROUPS - 1 : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_i,
    input  logic                load_i,
    input  logic [IDX_W-1:0]    load_idx_i,
    input  logic [TMR_W-1:0]    load_val_i,
    output logic [N_TIMERS-1:0] expired_o
);
    logic [N_GROUPS-1:0] grp_en;

    tbt_rate_sched #(.N_GROUPS(N_GROUPS), .CNT_W(CNT_W)) u_sched (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_i   (tick_i),
        .grp_en_o (grp_en)
    );

    for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
        tbt_timer_group #(
            .TMR_W (TMR_W),
            .SIZE  (TIMERS_PER_GROUP),
            .IDX_W (IDX_W),
            .BASE  (g * TIMERS_PER_GROUP)
        ) u_grp (
            .clk      (clk),
            .rst_n    (rst_n),
            .step_i   (grp_en[g]),
            .ld_i     (load_i),
            .ld_idx_i (load_idx_i),
            .ld_val_i (load_val_i),
            .zero_o   (expired_o[g*TIMERS_PER_GROUP +: TIMERS_PER_GROUP])
        );
    end

    AST_RESET_ALL_EXPIRED: assert property (@(posedge clk)
        !rst_n |=> &expired_o); // R9
    AST_OOR_LOAD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && 32'(load_idx_i) >= N_TIMERS && !tick_i) |=> $stable(expired_o)); // R10
    AST_NO_TICK_NO_EXPIRY: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(expired_o)); // R4

endmodule

// File: tb/tb_timer_bank.sv
`timescale 1ns/1ps
module tb_timer_bank;
    localparam int W   = 8;
    localparam int NG  = 3;
    localparam int TPG = 4;
    localparam int NT  = NG * TPG;
    localparam int IW  = 4;
    localparam int CM  = (1 << (NG - 1)) - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          tick_i = 1'b0;
    logic          load_i = 1'b0;
    logic [IW-1:0] load_idx_i = '0;
    logic [W-1:0]  load_val_i = '0;
    logic [NT-1:0] expired_o;

    int checks = 0;
    int failures = 0;
    int c = 0;  // bench view of the modulo counter, from R4

    always #2.5 clk = ~clk;

    timer_bank #(.TMR_W(W), .N_GROUPS(NG), .TIMERS_PER_GROUP(TPG)) dut (
        .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .load_i(load_i),
        .load_idx_i(load_idx_i), .load_val_i(load_val_i), .expired_o(expired_o)
    );

    task automatic chk(input logic [NT-1:0] act, input logic [NT-1:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Ticks until a timer in group g loaded with v reaches zero (R5/R6/R7).
    function automatic int ticks_to_zero(input int g, input int v, input int c0);
        int n = 0;
        int cc = c0;
        int m = (1 << g) - 1;
        while (v > 0) begin
            cc = (cc + 1) & CM;
            if ((cc & m) == m) v--;
            n++;
        end
        return n;
    endfunction

    task automatic do_tick();
        @(negedge clk) tick_i = 1'b1;
        @(negedge clk) tick_i = 1'b0;
        c = (c + 1) & CM;
    endtask

    task automatic do_load(input int idx, input int val);
        @(negedge clk) begin load_i = 1'b1; load_idx_i = IW'(idx); load_val_i = W'(val); end
        @(negedge clk) load_i = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        c = 0;
    endtask

    // Load one timer and check the exact expiry tick and that it stays at zero.
    task automatic run_case(input int idx, input int val, input string tag);
        int n;
        n = ticks_to_zero(idx / TPG, val, c);
        do_load(idx, val);
        chk(NT'(expired_o[idx]), NT'(0), {tag, " R1 running after load"});
        repeat (n - 1) do_tick();
        chk(NT'(expired_o[idx]), NT'(0), {tag, " one tick before expiry"});
        do_tick();
        chk(NT'(expired_o[idx]), NT'(1), {tag, " R3 expired on exact tick"});
        repeat (3) do_tick();
        chk(NT'(expired_o[idx]), NT'(1), {tag, " R2 no wrap below zero"});
    endtask

    task automatic t_reset();
        do_reset();
        chk(expired_o, '1, "R9 all expired after reset");
    endtask

    task automatic t_load_vs_step();
        int n;
        @(negedge clk) begin
            load_i = 1'b1; tick_i = 1'b1; load_idx_i = IW'(1); load_val_i = W'(2);
        end
        @(negedge clk) begin load_i = 1'b0; tick_i = 1'b0; end
        c = (c + 1) & CM;
        n = ticks_to_zero(0, 2, c);
        do_tick();
        chk(NT'(expired_o[1]), NT'(0), "R8 load beats same-cycle step");
        repeat (n - 1) do_tick();
        chk(NT'(expired_o[1]), NT'(1), "R8 full loaded count used");
    endtask

    task automatic t_zero_load();
        do_load(5, 10);
        chk(NT'(expired_o[5]), NT'(0), "R1 nonzero load clears flag");
        do_load(5, 0);
        chk(NT'(expired_o[5]), NT'(1), "R11 zero load expires at once");
    endtask

    task automatic t_hold();
        int n;
        do_load(8, 1);
        repeat (12) @(negedge clk);
        chk(NT'(expired_o[8]), NT'(0), "R4 no tick no change");
        n = ticks_to_zero(2, 1, c);
        repeat (n) do_tick();
        chk(NT'(expired_o[8]), NT'(1), "R4 resumes on ticks");
    endtask

    task automatic t_out_of_range();
        chk(expired_o, '1, "R10 precondition all expired");
        do_load(13, 50);
        chk(expired_o, '1, "R10 index 13 ignored");
        do_load(15, 7);
        chk(expired_o, '1, "R10 index 15 ignored");
    endtask

    task automatic t_mid_reset();
        do_load(4, 100);
        do_tick();
        do_reset();
        chk(expired_o, '1, "R9 reset mid-run");
        do_tick();  // counter from 0 -> 1: group 1 steps (R6)
        do_load(6, 1);
        do_tick();  // 1 -> 2: bit0 clear, no step
        chk(NT'(expired_o[6]), NT'(0), "R6 counter restarted, even phase skips");
        do_tick();  // 2 -> 3: step
        chk(NT'(expired_o[6]), NT'(1), "R6 odd phase steps");
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        t_reset();
        run_case(0, 3, "R5 group0 v3");
        run_case(4, 2, "R6 group1 v2");
        do_tick();
        run_case(5, 3, "R6 group1 shifted phase");
        run_case(9, 3, "R7 group2 v3");
        do_tick();
        run_case(10, 1, "R7 group2 v1 shifted");
        run_case(2, 255, "R1 group0 full byte");
        t_load_vs_step();
        t_zero_load();
        t_hold();
        t_out_of_range();
        t_mid_reset();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule